// File: doc/BRIEF.md
# Cache Snoop Inquire Responder

This block answers external coherency probes on behalf of a processor cache. An external agent presents a line address with a one-cycle inquire strobe. The block looks the address up in a small set-associative tag store that keeps a four-state coherency code for every line. One clock later it reports whether the line is present and whether it is dirty. The line's state then changes as the agent asks. With the invalidate request set, a present line is dropped. Without it, the line is demoted to the shared state.

A dirty line cannot change state straight away. The block first runs a four-beat writeback of that line, counted by burst-ready pulses. It offers the latched inquire address to the bus side for that writeback and keeps the dirty indication raised until the burst is finished. The new state is written only after the writeback completes. Every recognized inquire also has its address parity checked, and a mismatch gives a one-clock error pulse.

When the agent has taken the address bus with an address-hold request, an inquire counts only if that hold was already in place for two clocks. Lines are installed through a simple fill port driven by the cache's own refill logic.

Top module: `snoop_inquire_responder`

## Requirements
- R1: A recognized inquire strobe sampled at clock edge k updates `hit_o` and `hitm_o` at edge k+1. Neither output changes at edge k.
- R2: `hit_o` keeps its value until the next recognized inquire resolves. `hitm_o` is never high while `hit_o` is low.
- R3: A hit on a line in the shared or exclusive state sets `hit_o`=1 and `hitm_o`=0. The line's state is written at that same edge k+1: invalid (code 0) when `inv_i` was high with the strobe, shared (code 1) when it was low.
- R4: A hit on a modified line (code 3) raises `hitm_o` and `wb_busy_o` at edge k+1. `wb_addr_o` then carries inquire address bits [31:5] and stays constant for the whole writeback. The line's state is updated only after the writeback ends.
- R5: The writeback lasts until the fourth `brdy_i` pulse. `wb_busy_o` falls at the edge that samples that last ready, and `hitm_o` falls one edge later.
- R6: While `ahold_i` is high, a strobe is recognized only if `ahold_i` was also sampled high on the two edges before the strobe's edge. Otherwise the strobe is ignored. With `ahold_i` low, every strobe in the idle state is recognized.
- R7: `apchk_o` pulses high for exactly one clock, at edge k+1, when a recognized inquire's `ap_i` differs from the XOR of `inq_addr_i[31:3]` (even parity). The inquire itself still proceeds.
- R8: A strobe that arrives while a previous inquire is resolving or its writeback is running is ignored. It changes no output and no line state.
- R9: After reset, `hit_o`, `hitm_o`, `apchk_o` and `wb_busy_o` are 0 and every line is invalid.
- R10: `fill_en_i` writes tag `fill_addr_i[31:8]` and state `fill_state_i` into set `fill_addr_i[7:5]`, way `fill_way_i`. State codes: 0 invalid, 1 shared, 2 exclusive, 3 modified.
- R11: An inquire that finds no valid matching line drives `hit_o` and `hitm_o` low and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eads_i | input | 1 | Inquire strobe, one cycle |
| inq_addr_i | input | 29 | Inquire address bits [31:3] |
| ap_i | input | 1 | Even parity bit for the inquire address |
| inv_i | input | 1 | Invalidate request, sampled with the strobe |
| ahold_i | input | 1 | Address-hold request from the agent |
| brdy_i | input | 1 | Burst-ready pulse for writeback beats |
| fill_en_i | input | 1 | Line install enable |
| fill_addr_i | input | 27 | Install address bits [31:5] |
| fill_way_i | input | 1 | Install way |
| fill_state_i | input | 2 | Install state code |
| hit_o | output | 1 | Line present (sticky) |
| hitm_o | output | 1 | Line present and modified |
| apchk_o | output | 1 | Address parity error pulse |
| wb_busy_o | output | 1 | Writeback burst in progress |
| wb_addr_o | output | 27 | Writeback line address bits [31:5] |

## Verification
Parity checking and the dirty-line response can land on the same clock edge. The bench provokes this with a wrong `ap_i` on an inquire to a modified line, and expects `apchk_o`, `hit_o` and `hitm_o` all high at edge k+1, followed by a normal writeback. A second overlap is a new strobe arriving in the middle of a writeback burst. That strobe is judged ignored when the sticky outputs keep their values, and when a later inquire still finds the targeted line in the shared state.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        SN_IDLE,
        SN_RESOLVE,
        SN_WB_BURST,
        SN_WB_CLOSE
    } snoop_st_t;
endpackage

// File: rtl/snoop_hold_qual.sv
module snoop_hold_qual #(
    parameter int ADDR_W   = 32,
    parameter int HOLD_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ahold_i,
    input  logic              eads_i,
    input  logic [ADDR_W-1:3] addr_i,
    input  logic              ap_i,
    output logic              strobe_ok_o,
    output logic              par_err_o
);
    localparam int RUN_W = $clog2(HOLD_MIN + 1);

    logic [RUN_W-1:0] run_q;

    // consecutive address-hold samples, saturating at HOLD_MIN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!ahold_i) begin
            run_q <= '0;
        end else if (run_q < RUN_W'(HOLD_MIN)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign strobe_ok_o = eads_i && (!ahold_i || (run_q >= RUN_W'(HOLD_MIN)));
    assign par_err_o   = (^addr_i) != ap_i;
endmodule

// File: rtl/snoop_tag_store.sv
module snoop_tag_store
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int SETS   = 8,
    parameter int WAYS   = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:OFF_W] lk_addr_i,
    output logic                  lk_hit_o,
    output logic [WAY_W-1:0]      lk_way_o,
    output line_st_t              lk_state_o,
    input  logic                  up_en_i,
    input  logic [IDX_W-1:0]      up_idx_i,
    input  logic [WAY_W-1:0]      up_way_i,
    input  line_st_t              up_state_i,
    input  logic                  fill_en_i,
    input  logic [ADDR_W-1:OFF_W] fill_addr_i,
    input  logic [WAY_W-1:0]      fill_way_i,
    input  line_st_t              fill_state_i
);
    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic [WAYS-1:0]  way_match;
    line_st_t         way_st [WAYS];

    assign lk_idx   = lk_addr_i[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr_i[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr_i[OFF_W +: IDX_W];
    assign fill_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        line_st_t         st_q  [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_q[s] <= '0;
                    st_q[s]  <= LN_INV;
                end
            end else begin
                if (fill_en_i && fill_way_i == WAY_W'(gw)) begin
                    tag_q[fill_idx] <= fill_tag;
                    st_q[fill_idx]  <= fill_state_i;
                end
                // snoop update is written last so it wins a collision
                if (up_en_i && up_way_i == WAY_W'(gw)) begin
                    st_q[up_idx_i] <= up_state_i;
                end
            end
        end

        assign way_match[gw] = (st_q[lk_idx] != LN_INV) && (tag_q[lk_idx] == lk_tag);
        assign way_st[gw]    = st_q[lk_idx];
    end

    always_comb begin
        lk_hit_o   = 1'b0;
        lk_way_o   = '0;
        lk_state_o = LN_INV;
        for (int w = 0; w < WAYS; w++) begin
            if (!lk_hit_o && way_match[w]) begin
                lk_hit_o   = 1'b1;
                lk_way_o   = WAY_W'(w);
                lk_state_o = way_st[w];
            end
        end
    end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
    import snoop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int WAY_W  = 1,
    parameter int BEATS  = 4,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe_ok_i,
    input  logic                  par_err_i,
    input  logic [ADDR_W-1:OFF_W] inq_line_i,
    input  logic                  inv_i,
    input  logic                  brdy_i,
    input  logic                  lk_hit_i,
    input  logic [WAY_W-1:0]      lk_way_i,
    input  line_st_t              lk_state_i,
    output logic [ADDR_W-1:OFF_W] line_q_o,
    output logic                  up_en_o,
    output logic [WAY_W-1:0]      up_way_o,
    output line_st_t              up_state_o,
    output logic                  hit_o,
    output logic                  hitm_o,
    output logic                  apchk_o,
    output logic                  wb_busy_o
);
    snoop_st_t         cur_q, nxt;
    logic              inv_q, perr_q;
    logic [WAY_W-1:0]  way_q;
    logic [BEAT_W-1:0] beat_q;
    logic              dirty_hit, last_beat;

    assign dirty_hit = lk_hit_i && (lk_state_i == LN_MOD);
    assign last_beat = brdy_i && (beat_q == BEAT_W'(BEATS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= SN_IDLE;
        else        cur_q <= nxt;
    end

    // transitions
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            SN_IDLE:     if (strobe_ok_i) nxt = SN_RESOLVE;
            SN_RESOLVE:  nxt = dirty_hit ? SN_WB_BURST : SN_IDLE;
            SN_WB_BURST: if (last_beat) nxt = SN_WB_CLOSE;
            SN_WB_CLOSE: nxt = SN_IDLE;
        endcase
    end

    // registered outputs and captured inquire context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q_o  <= '0;
            inv_q     <= 1'b0;
            perr_q    <= 1'b0;
            way_q     <= '0;
            beat_q    <= '0;
            hit_o     <= 1'b0;
            hitm_o    <= 1'b0;
            apchk_o   <= 1'b0;
            wb_busy_o <= 1'b0;
        end else begin
            apchk_o <= 1'b0;
            unique case (cur_q)
                SN_IDLE: begin
                    if (strobe_ok_i) begin
                        line_q_o <= inq_line_i;
                        inv_q    <= inv_i;
                        perr_q   <= par_err_i;
                    end
                end
                SN_RESOLVE: begin
                    hit_o     <= lk_hit_i;
                    hitm_o    <= dirty_hit;
                    apchk_o   <= perr_q;
                    way_q     <= lk_way_i;
                    wb_busy_o <= dirty_hit;
                    beat_q    <= '0;
                end
                SN_WB_BURST: begin
                    if (brdy_i) beat_q <= beat_q + 1'b1;
                    if (last_beat) wb_busy_o <= 1'b0;
                end
                SN_WB_CLOSE: begin
                    hitm_o <= 1'b0;
                end
            endcase
        end
    end

    // line state write: clean hit at resolve, dirty hit after its burst
    always_comb begin
        up_en_o    = ((cur_q == SN_RESOLVE) && lk_hit_i && !dirty_hit)
                   || (cur_q == SN_WB_CLOSE);
        up_way_o   = (cur_q == SN_RESOLVE) ? lk_way_i : way_q;
        up_state_o = inv_q ? LN_INV : LN_SHR;
    end
endmodule

// File: rtl/snoop_inquire_responder.sv
module snoop_inquire_responder
    import snoop_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 5,
    parameter int SETS     = 8,
    parameter int WAYS     = 2,
    parameter int BEATS    = 4,
    parameter int HOLD_MIN = 2,
    localparam int IDX_W   = $clog2(SETS),
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  eads_i,
    input  logic [ADDR_W-1:3]     inq_addr_i,
    input  logic                  ap_i,
    input  logic                  inv_i,
    input  logic                  ahold_i,
    input  logic                  brdy_i,
    input  logic                  fill_en_i,
    input  logic [ADDR_W-1:OFF_W] fill_addr_i,
    input  logic [WAY_W-1:0]      fill_way_i,
    input  logic [1:0]            fill_state_i,
    output logic                  hit_o,
    output logic                  hitm_o,
    output logic                  apchk_o,
    output logic                  wb_busy_o,
    output logic [ADDR_W-1:OFF_W] wb_addr_o
);
    logic                  strobe_ok, par_err;
    logic [ADDR_W-1:OFF_W] line_q;
    logic                  lk_hit;
    logic [WAY_W-1:0]      lk_way;
    line_st_t              lk_state;
    logic                  up_en;
    logic [WAY_W-1:0]      up_way;
    line_st_t              up_state;

    snoop_hold_qual #(.ADDR_W(ADDR_W), .HOLD_MIN(HOLD_MIN)) u_qual (
        .clk(clk), .rst_n(rst_n), .ahold_i(ahold_i), .eads_i(eads_i),
        .addr_i(inq_addr_i), .ap_i(ap_i),
        .strobe_ok_o(strobe_ok), .par_err_o(par_err)
    );

    snoop_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_addr_i(line_q), .lk_hit_o(lk_hit), .lk_way_o(lk_way), .lk_state_o(lk_state),
        .up_en_i(up_en), .up_idx_i(line_q[OFF_W +: IDX_W]), .up_way_i(up_way),
        .up_state_i(up_state),
        .fill_en_i(fill_en_i), .fill_addr_i(fill_addr_i), .fill_way_i(fill_way_i),
        .fill_state_i(line_st_t'(fill_state_i))
    );

    snoop_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAY_W(WAY_W), .BEATS(BEATS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .strobe_ok_i(strobe_ok), .par_err_i(par_err),
        .inq_line_i(inq_addr_i[ADDR_W-1:OFF_W]), .inv_i(inv_i), .brdy_i(brdy_i),
        .lk_hit_i(lk_hit), .lk_way_i(lk_way), .lk_state_i(lk_state),
        .line_q_o(line_q), .up_en_o(up_en), .up_way_o(up_way), .up_state_o(up_state),
        .hit_o(hit_o), .hitm_o(hitm_o), .apchk_o(apchk_o), .wb_busy_o(wb_busy_o)
    );

    assign wb_addr_o = line_q;
endmodule

// File: rtl/snoop_inquire_checker.sv
module snoop_inquire_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  eads_i,
    input logic                  brdy_i,
    input logic                  hit_o,
    input logic                  hitm_o,
    input logic                  apchk_o,
    input logic                  wb_busy_o,
    input logic [ADDR_W-1:OFF_W] wb_addr_o
);
    assert_hitm_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hitm_o |-> hit_o);

    assert_hit_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != $past(hit_o)) |-> $past(eads_i, 2));

    assert_apchk_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        apchk_o |=> !apchk_o);

    assert_wb_under_hitm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_busy_o |-> hitm_o);

    assert_hitm_drop_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hitm_o) |-> $past(brdy_i, 2));

    assert_wb_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_busy_o && $past(wb_busy_o)) |-> $stable(wb_addr_o));
endmodule

bind snoop_inquire_responder snoop_inquire_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eads_i(eads_i), .brdy_i(brdy_i),
    .hit_o(hit_o), .hitm_o(hitm_o), .apchk_o(apchk_o),
    .wb_busy_o(wb_busy_o), .wb_addr_o(wb_addr_o)
);

// File: tb/tb_snoop_inquire_responder.sv
`timescale 1ns/1ps
module tb_snoop_inquire_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eads_i = 1'b0, ap_i = 1'b0, inv_i = 1'b0, ahold_i = 1'b0, brdy_i = 1'b0;
    logic [31:3] inq_addr_i = '0;
    logic        fill_en_i = 1'b0;
    logic [31:5] fill_addr_i = '0;
    logic        fill_way_i = 1'b0;
    logic [1:0]  fill_state_i = '0;
    logic        hit_o, hitm_o, apchk_o, wb_busy_o;
    logic [31:5] wb_addr_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snoop_inquire_responder dut (
        .clk(clk), .rst_n(rst_n), .eads_i(eads_i), .inq_addr_i(inq_addr_i),
        .ap_i(ap_i), .inv_i(inv_i), .ahold_i(ahold_i), .brdy_i(brdy_i),
        .fill_en_i(fill_en_i), .fill_addr_i(fill_addr_i), .fill_way_i(fill_way_i),
        .fill_state_i(fill_state_i),
        .hit_o(hit_o), .hitm_o(hitm_o), .apchk_o(apchk_o),
        .wb_busy_o(wb_busy_o), .wb_addr_o(wb_addr_o)
    );

    typedef struct {
        logic  hit;
        logic  hitm;
        logic  apchk;
        string req;
    } exp_t;
    exp_t exp_q[$];

    logic eads_d1 = 1'b0, eads_d2 = 1'b0;
    always @(posedge clk) begin
        eads_d1 <= eads_i;
        eads_d2 <= eads_d1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: result of a strobe sampled at edge k is visible after edge k+1
    always @(negedge clk) begin
        if (eads_d2 && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.req, " hit"},   32'(hit_o),   32'(e.hit));
            check({e.req, " hitm"},  32'(hitm_o),  32'(e.hitm));
            check({e.req, " apchk"}, 32'(apchk_o), 32'(e.apchk));
        end
    end

    task automatic fill(input logic [31:0] a, input logic w, input logic [1:0] st);
        @(negedge clk);
        fill_en_i = 1'b1; fill_addr_i = a[31:5]; fill_way_i = w; fill_state_i = st;
        @(negedge clk);
        fill_en_i = 1'b0;
    endtask

    task automatic inquire(input logic [31:0] a, input logic inv, input logic bad_par,
                           input logic e_hit, input logic e_hitm, input logic e_apchk,
                           input string req);
        exp_t e;
        e.hit = e_hit; e.hitm = e_hitm; e.apchk = e_apchk; e.req = req;
        @(negedge clk);
        exp_q.push_back(e);
        eads_i = 1'b1; inq_addr_i = a[31:3]; inv_i = inv; ap_i = (^a[31:3]) ^ bad_par;
        @(negedge clk);
        eads_i = 1'b0; inv_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({req, " apchk one clock"}, 32'(apchk_o), 32'(0));
    endtask

    task automatic beat();
        @(negedge clk); brdy_i = 1'b1;
        @(negedge clk); brdy_i = 1'b0;
    endtask

    localparam logic [31:0] LA = 32'h1234_5620; // set 1
    localparam logic [31:0] LB = 32'h0ABC_D020; // set 1
    localparam logic [31:0] LC = 32'h0000_1040; // set 2
    localparam logic [31:0] LD = 32'h7777_7060; // set 3
    localparam logic [31:0] LG = 32'h9999_9020; // set 1, absent

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 hit after reset",   32'(hit_o),     32'(0));
        check("R9 hitm after reset",  32'(hitm_o),    32'(0));
        check("R9 apchk after reset", 32'(apchk_o),   32'(0));
        check("R9 busy after reset",  32'(wb_busy_o), 32'(0));
        inquire(LA, 1'b0, 1'b0, 0, 0, 0, "R9 empty store misses");

        // R10 install lines: 1 shared, 2 exclusive, 3 modified
        fill(LA, 1'b0, 2'd2);
        fill(LB, 1'b1, 2'd1);
        fill(LC, 1'b0, 2'd3);
        fill(LD, 1'b1, 2'd3);

        // R1 R3 clean hit, demote then drop
        inquire(LA, 1'b0, 1'b0, 1, 0, 0, "R1 R3 exclusive hit");
        inquire(LA, 1'b1, 1'b0, 1, 0, 0, "R3 now shared hit");
        inquire(LA, 1'b0, 1'b0, 0, 0, 0, "R3 invalidated line misses");
        inquire(LG, 1'b0, 1'b0, 0, 0, 0, "R11 absent tag misses");
        inquire(LB, 1'b0, 1'b0, 1, 0, 0, "R10 way1 hit");

        // R4 R5 R7 dirty hit with parity error in the same cycle
        inquire(LC, 1'b0, 1'b1, 1, 1, 1, "R7 R4 dirty hit with parity error");
        check("R4 busy during burst", 32'(wb_busy_o), 32'(1));
        check("R4 writeback address", 32'(wb_addr_o), 32'(LC[31:5]));
        beat();
        check("R5 hitm after beat 1", 32'(hitm_o), 32'(1));
        beat();
        // R8 strobe during burst is ignored
        inquire(LB, 1'b1, 1'b0, 1, 1, 0, "R8 strobe in burst ignored");
        beat();
        check("R5 busy before last beat", 32'(wb_busy_o), 32'(1));
        beat();
        check("R5 hitm one clock after last ready", 32'(hitm_o), 32'(1));
        check("R5 busy falls at last ready", 32'(wb_busy_o), 32'(0));
        check("R2 hit stays during burst", 32'(hit_o), 32'(1));
        @(negedge clk);
        check("R5 hitm dropped", 32'(hitm_o), 32'(0));
        check("R2 hit still sticky", 32'(hit_o), 32'(1));
        inquire(LC, 1'b1, 1'b0, 1, 0, 0, "R4 shared after writeback");
        inquire(LC, 1'b0, 1'b0, 0, 0, 0, "R3 dropped after invalidate");
        inquire(LB, 1'b0, 1'b0, 1, 0, 0, "R8 ignored strobe left line");

        // R6 address-hold qualification
        inquire(LG, 1'b0, 1'b0, 0, 0, 0, "R11 miss before hold test");
        @(negedge clk); ahold_i = 1'b1;
        inquire(LD, 1'b0, 1'b0, 0, 0, 0, "R6 short hold ignored");
        @(negedge clk); ahold_i = 1'b0;
        @(negedge clk); ahold_i = 1'b1;
        @(negedge clk);
        inquire(LD, 1'b1, 1'b0, 1, 1, 0, "R6 long hold accepted");
        check("R4 address on dirty hit", 32'(wb_addr_o), 32'(LD[31:5]));
        for (int i = 0; i < 4; i++) beat();
        @(negedge clk);
        check("R5 hitm clear after burst", 32'(hitm_o), 32'(0));
        ahold_i = 1'b0;
        inquire(LD, 1'b0, 1'b0, 0, 0, 0, "R4 line dropped after writeback");

        repeat (3) @(negedge clk);
        check("R1 all results consumed", 32'(exp_q.size()), 32'(0));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule